// File: doc/BRIEF.md
# Crosstalk-Aware Variable-Cycle Bus Transmitter

This block drives words onto a wide parallel on-chip bus whose wires couple capacitively to their neighbours. Instead of holding every word on the wires for a fixed worst-case time, it looks at the word about to be sent and the word currently on the bus. From the two it works out how badly each wire will be slowed by its neighbours, and holds the new word only as long as the slowest wire needs.

Each wire's change is sorted as rising, falling or quiet. A quiet wire gets delay class 1. A switching wire gets a class from the sum of two neighbour terms, and the sum is floored at 1. A quiet neighbour adds 1. A neighbour moving the same way adds 0. A neighbour moving the opposite way adds 2. A missing neighbour at either edge of the bus adds 0. The largest class over the bus, from 1 to 4, is the number of cycles the word stays on the wires.

Words come in through a valid/ready handshake. The receiver samples the bus when the single-cycle strobe is high, and the strobe marks the last cycle of the hold.

Top module: `xt_vcyc_tx`

## Requirements
- R1: After reset, `bus_data` is all zeros, `bus_strobe` is low and `in_ready` is high.
- R2: `in_ready` is low for the whole hold of a word. While it is low, `in_valid` and `in_data` have no effect: `bus_data` stays equal to the word being held, and the hold length does not change.
- R3: A word equal to the one already on the bus is held for exactly 1 cycle.
- R4: The hold length is the largest per-wire class. Take bit 7 as the leftmost wire. Then 0x49 to 0x34 holds 4 cycles, and both 0x59 to 0x34 and 0x34 to 0x59 hold 3 cycles.
- R5: When every switching wire moves the same way as all of its switching neighbours, each class floors at 1. For example, 0x00 to 0xFF holds 1 cycle.
- R6: A lone switching wire between two quiet wires has class 2. A lone switching wire at the edge of the bus, next to a quiet wire, has class 1. So 0x02 to 0x03 holds 1 cycle, and 0x03 to 0x49 holds 2 cycles.
- R7: Neighbours switching in opposite directions give class 4. For example, 0x55 to 0xAA holds 4 cycles.
- R8: `bus_strobe` is high for exactly one cycle per word, in the last cycle of its hold, and `in_ready` returns high in the following cycle.
- R9: The first word after reset is compared against an all-zero previous word. For example, a first word of 0x02 holds 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | High when no word is being held; the word is taken when `in_valid` is also high |
| in_data | input | WIDTH | Word to send |
| bus_data | output | WIDTH | Bus wires, holding the current word |
| bus_strobe | output | 1 | High in the last hold cycle; the receiver samples `bus_data` then |

## Verification
The hardest cases to reach from the ports are the ones that depend on the previous word, because a class comes from the pair of words and not from one word alone. That covers the edge-wire rule, the opposite-neighbour maximum of 4, and the floor at 1. The stimulus therefore sends a fixed chain of words, each chosen so that its pairing with the word before it lands on one specific corner, and it checks the hold length of every word. To show that input is ignored during a hold, junk is offered in the middle of a 4-cycle hold, and the bench then checks that the bus contents and the hold length are unchanged.

// File: rtl/xt_pkg.sv
// Package: shared widths and the neighbour cost rule for the transmitter.
// Assumes a class never exceeds 4, so three bits are enough.
package xt_pkg;
    localparam int CLS_W   = 3;
    localparam int CLS_MAX = 4;

    typedef logic [CLS_W-1:0] cls_t;

    // Cost a neighbour adds to a switching wire whose direction is self_up.
    function automatic cls_t nb_cost(input logic self_up,
                                     input logic nb_up,
                                     input logic nb_dn);
        if (!nb_up && !nb_dn)  return cls_t'(1);
        if (nb_up == self_up)  return cls_t'(0);
        return cls_t'(2);
    endfunction
endpackage

// File: rtl/xt_classify.sv
// Per-wire crosstalk classifier. It compares the previous and next word
// and gives each wire a delay class from 1 to 4. Edge wires see a missing
// neighbour, which adds nothing. Purely combinational.
module xt_classify
    import xt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]       prev_word,
    input  logic [WIDTH-1:0]       next_word,
    output logic [WIDTH*CLS_W-1:0] cls_flat
);
    logic [WIDTH-1:0] up;
    logic [WIDTH-1:0] dn;

    // Sort each wire into rising, falling or quiet.
    always_comb begin
        up = ~prev_word & next_word;
        dn = prev_word & ~next_word;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_wire
        cls_t lo_c, hi_c, sum_c;

        // Add up the two neighbour terms, treating a missing edge neighbour as 0.
        always_comb begin
            if (i == 0) lo_c = '0;
            else        lo_c = nb_cost(up[i], up[(i == 0) ? 0 : i-1], dn[(i == 0) ? 0 : i-1]);
            if (i == WIDTH-1) hi_c = '0;
            else              hi_c = nb_cost(up[i], up[(i == WIDTH-1) ? i : i+1], dn[(i == WIDTH-1) ? i : i+1]);
            sum_c = lo_c + hi_c;
        end

        // A quiet wire is class 1; a switching wire takes the sum floored at 1.
        always_comb begin
            if (!(up[i] || dn[i]))   cls_flat[i*CLS_W +: CLS_W] = cls_t'(1);
            else if (sum_c == '0)    cls_flat[i*CLS_W +: CLS_W] = cls_t'(1);
            else                     cls_flat[i*CLS_W +: CLS_W] = sum_c;
        end
    end
endmodule

// File: rtl/xt_max_reduce.sv
// Maximum over all per-wire classes, which gives the hold length in cycles.
// Assumes every class is already between 1 and 4.
module xt_max_reduce
    import xt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH*CLS_W-1:0] cls_flat,
    output cls_t                   cls_max
);
    // Linear scan for the largest class.
    always_comb begin
        cls_max = cls_t'(1);
        for (int i = 0; i < WIDTH; i++) begin
            if (cls_flat[i*CLS_W +: CLS_W] > cls_max)
                cls_max = cls_flat[i*CLS_W +: CLS_W];
        end
    end
endmodule

// File: rtl/xt_hold_ctrl.sv
// Hold counter. It loads the hold length when a word is taken and counts
// down to zero. It reports busy while counting and flags the last cycle.
// Assumes accept only arrives while not busy.
module xt_hold_ctrl
    import xt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  cls_t hold_len,
    output logic busy,
    output logic last
);
    cls_t remain_q;

    // Load on accept, otherwise count down while a hold is running.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain_q <= '0;
        else if (accept)        remain_q <= hold_len;
        else if (remain_q != 0) remain_q <= remain_q - cls_t'(1);
    end

    // Decode the busy and last-cycle flags.
    always_comb begin
        busy = (remain_q != '0);
        last = (remain_q == cls_t'(1));
    end

    a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (hold_len >= cls_t'(1) && hold_len <= cls_t'(CLS_MAX)));
    a_r8_last_then_free: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hold_len == cls_t'(1)) |=> last);
endmodule

// File: rtl/xt_vcyc_tx.sv
// Top level: crosstalk-aware variable-cycle bus transmitter. It takes a word
// when idle, drives it on the bus register, and holds it for the worst wire
// class against the previous bus word. The strobe marks the last cycle.
// Assumes the receiver samples bus_data only when bus_strobe is high.
module xt_vcyc_tx
    import xt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] bus_data,
    output logic             bus_strobe
);
    logic [WIDTH*CLS_W-1:0] cls_flat;
    cls_t                   cls_max;
    logic                   busy;
    logic                   accept;

    xt_classify #(.WIDTH(WIDTH)) u_cls (
        .prev_word (bus_data),
        .next_word (in_data),
        .cls_flat  (cls_flat)
    );

    xt_max_reduce #(.WIDTH(WIDTH)) u_max (
        .cls_flat (cls_flat),
        .cls_max  (cls_max)
    );

    xt_hold_ctrl u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .hold_len (cls_max),
        .busy     (busy),
        .last     (bus_strobe)
    );

    // Handshake: take a word only when nothing is held.
    always_comb begin
        in_ready = !busy;
        accept   = in_valid && in_ready;
    end

    // Bus register: starts at zero, loads the word when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_data <= '0;
        else if (accept) bus_data <= in_data;
    end

    a_r2_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(bus_data));
    a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> !in_ready);
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe);

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        a_r3_quiet_class: assert property (@(posedge clk) disable iff (!rst_n)
            (in_data[i] == bus_data[i]) |-> (cls_flat[i*CLS_W +: CLS_W] == cls_t'(1)));
        a_r4_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cls_flat[i*CLS_W +: CLS_W] <= cls_max);
    end
endmodule

// File: tb/xt_vcyc_tx_tb.sv
// Directed bench for the transmitter: one task per scenario, each self-checking.
module xt_vcyc_tx_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic [W-1:0] bus_data;
    logic         bus_strobe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xt_vcyc_tx #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .bus_data   (bus_data),
        .bus_strobe (bus_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Send one word. Count the hold cycles up to the strobe and check the bus
    // contents, ready and the strobe. If junk_at > 0, offer junk at that cycle.
    task automatic send(input logic [W-1:0] word, input int exp_len,
                        input string req, input int junk_at);
        int  len = 0;
        bit  bus_ok = 1'b1;
        bit  rdy_ok = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = word;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~word;
        for (int k = 1; k <= 8; k++) begin
            if (bus_data !== word) bus_ok = 1'b0;
            if (in_ready !== 1'b0) rdy_ok = 1'b0;
            if (k == junk_at) begin
                in_valid = 1'b1;
                in_data  = 8'h00;
            end
            if (bus_strobe === 1'b1) begin
                len = k;
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(bus_ok, req, "bus held word", int'(bus_data), int'(word));
        check(rdy_ok, "R2", "ready low in hold", int'(in_ready), 0);
        check(len == exp_len, req, "hold cycles", len, exp_len);
        @(negedge clk);
        check(in_ready === 1'b1 && bus_strobe === 1'b0, "R8", "ready back, strobe low",
              int'({in_ready, bus_strobe}), 2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_data === '0, "R1", "bus after reset", int'(bus_data), 0);
        check(bus_strobe === 1'b0, "R1", "strobe after reset", int'(bus_strobe), 0);
        check(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_first_word();  // R9: compared against zero
        send(8'h02, 2, "R9", 0);
    endtask

    task automatic t_repeat();      // R3
        send(8'h02, 1, "R3", 0);
    endtask

    task automatic t_isolated();    // R6: edge wire 1, interior 2
        send(8'h03, 1, "R6", 0);
        send(8'h49, 2, "R6", 0);
    endtask

    task automatic t_examples();    // R4
        send(8'h34, 4, "R4", 0);
        send(8'h59, 3, "R4", 0);
        send(8'h34, 3, "R4", 0);
    endtask

    task automatic t_same_dir();    // R5
        send(8'h00, 2, "R6", 0);
        send(8'hFF, 1, "R5", 0);
    endtask

    task automatic t_opposite();    // R7
        send(8'h55, 2, "R6", 0);
        send(8'hAA, 4, "R7", 0);
    endtask

    task automatic t_ignore_busy(); // R2: junk offered mid-hold is ignored
        send(8'h55, 4, "R2", 2);
        check(bus_data === 8'h55, "R2", "bus after junk", int'(bus_data), 8'h55);
    endtask

    initial begin
        t_reset();
        t_first_word();
        t_repeat();
        t_isolated();
        t_examples();
        t_same_dir();
        t_opposite();
        t_ignore_busy();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule